// File: doc/BRIEF.md
# Memory Write Request Packetizer

This block turns a single memory write command into one request packet on a 128-bit AXI4-Stream master. A command carries a 64-bit byte address, a length in 32-bit words, first and last byte-enable nibbles, and a packing mode. The payload words arrive separately through a push port into an internal word FIFO. Each packet begins with a 16-byte descriptor. The payload follows it, either packed into the next free word lane or, in address-aligned mode, starting in the beat after the descriptor at the lane chosen by the low address bits. Word lanes that carry data are flagged in `m_tkeep`, with one bit per 32-bit word. The byte enables and the lane offset travel in `m_tuser` on the first beat.

A command is accepted only when every payload word it needs is already in the FIFO. Once a packet starts, `m_tvalid` therefore never drops before `m_tlast`. A write of length zero is sent as one dummy word with both byte-enable fields cleared, and it takes nothing from the FIFO.

Top module: `mwp_packetizer`

## Requirements
- R1: The first beat carries the descriptor in word lanes 0 to 3. Lane 0 holds address bits 31:2 with bits 1:0 zero, and lane 1 holds address bits 63:32. Lane 2 holds the word count in bits 10:0, which is 1 for a zero-length write, and the type code `WR_TYPE` (default 4'b0001) in bits 14:11. Lane 3 and all other bits of lane 2 are zero.
- R2: In packed mode the first payload word takes the word slot directly after the descriptor (slot 4). With four lanes this is lane 0 of the second beat, and later words fill consecutive slots.
- R3: In address-aligned mode the payload starts in the beat after the descriptor, at lane (address bits [3:2] for four lanes). Lanes before it in that beat carry zero and are kept.
- R4: `m_tuser` bits 3:0 carry the first byte enables, bits 7:4 the last byte enables, and bits 10:8 the payload start lane. The start lane is zero in packed mode. These values appear on the first beat only, and `m_tuser` is zero on every other beat.
- R5: `m_tkeep` is set from lane 0 of the first beat up to the last payload word without holes. Every beat except the last has all bits set.
- R6: `m_tvalid` stays high from the first beat to the beat with `m_tlast` with no gap. `m_tlast` is set on the final beat only.
- R7: While `m_tvalid` is high and `m_tready` is low, `m_tdata`, `m_tkeep`, `m_tlast` and `m_tuser` hold their values.
- R8: A zero-length write produces one payload word of value zero, with both byte-enable fields of `m_tuser` set to zero.
- R9: A zero-length write takes no word from the payload FIFO, so the next packet carries the words that were queued before it.
- R10: `cmd_ready` is high only when no packet is in flight and the FIFO holds at least `cmd_dw_len` words.
- R11: After reset `m_tvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with `cmd_valid` |
| cmd_addr | input | 64 | Byte address of the write |
| cmd_dw_len | input | 11 | Payload length in 32-bit words, 0 for a zero-length write |
| cmd_first_be | input | 4 | Byte enables of the first payload word |
| cmd_last_be | input | 4 | Byte enables of the last payload word |
| cmd_addr_aligned | input | 1 | 1 selects address-aligned payload placement, 0 selects packed |
| pl_valid | input | 1 | Payload word offered |
| pl_data | input | 32 | Payload word |
| pl_ready | output | 1 | FIFO has room for a word |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 32*LANES | Stream data, lane k in bits 32k+31:32k |
| m_tkeep | output | LANES | One bit per word lane |
| m_tlast | output | 1 | Final beat of a packet |
| m_tuser | output | 11 | First BE, last BE, payload start lane |

## Verification
The properties assume that a command's length never exceeds the FIFO depth, so that every accepted command can be fully backed by stored words. They also assume the payload words of a packet are pushed before its command is offered. The bench keeps lengths at or below twelve words with a sixteen-word FIFO, and it always pushes a packet's words before raising `cmd_valid`. Sink backpressure is randomised on most beats so that the hold properties see long stalls mid-packet as well as on first and last beats.

// File: rtl/mwp_pkg.sv
package mwp_pkg;

   localparam int WORD_BITS = 32;
   localparam int DESC_WORDS = 4;
   localparam int CNT_BITS = 11;
   localparam int USER_BITS = 11;

   typedef struct packed {
      logic [63:0]          addr;
      logic [CNT_BITS-1:0]  len;
      logic [3:0]           first_be;
      logic [3:0]           last_be;
      logic                 aligned;
   } mwp_cmd_t;

   // Descriptor word by index; zero length reports a count of one.
   function automatic logic [WORD_BITS-1:0] desc_word(input mwp_cmd_t c,
                                                      input int idx,
                                                      input logic [3:0] typ);
      logic [CNT_BITS-1:0] cnt;
      cnt = (c.len == '0) ? CNT_BITS'(1) : c.len;
      case (idx)
         0:       desc_word = {c.addr[31:2], 2'b00};
         1:       desc_word = c.addr[63:32];
         2:       desc_word = {17'd0, typ, cnt};
         default: desc_word = '0;
      endcase
   endfunction

endpackage

// File: rtl/mwp_dw_fifo.sv
module mwp_dw_fifo #(
   parameter int DEPTH = 16,
   parameter int LANES = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1,
   localparam int POP_W = $clog2(LANES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   push_valid,
   input  logic [31:0]            push_data,
   output logic                   push_ready,
   input  logic [POP_W-1:0]       pop_cnt,
   output logic [LANES-1:0][31:0] win,
   output logic [CNT_W-1:0]       level
);

   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("mwp_dw_fifo: DEPTH must be a power of two");
   end
   if (DEPTH < LANES) begin : g_bad_small
      $error("mwp_dw_fifo: DEPTH must be at least LANES");
   end

   logic [31:0]      mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [CNT_W-1:0] level_q;
   logic             push_fire;

   assign push_ready = (level_q != CNT_W'(DEPTH));
   assign push_fire  = push_valid && push_ready;
   assign level      = level_q;

   always_ff @(posedge clk) begin
      if (push_fire) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else begin
         if (push_fire) wr_ptr <= wr_ptr + PTR_W'(1);
         rd_ptr  <= rd_ptr + PTR_W'(pop_cnt);
         level_q <= level_q + CNT_W'(push_fire) - CNT_W'(pop_cnt);
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_win
      assign win[k] = mem[rd_ptr + PTR_W'(k)];
   end

endmodule

// File: rtl/mwp_seq.sv
module mwp_seq
   import mwp_pkg::*;
#(
   parameter int LANES = 4,
   parameter int DEPTH = 16,
   parameter int SLOT_W = 13,
   localparam int LANE_SH = $clog2(LANES),
   localparam int CNT_W = $clog2(DEPTH) + 1,
   localparam int POP_W = $clog2(LANES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  mwp_cmd_t           cmd_in,
   output logic               cmd_ready,
   input  logic [CNT_W-1:0]   level,
   input  logic               beat_fire,
   output logic               busy,
   output mwp_cmd_t           cmd_q,
   output logic [SLOT_W-1:0]  bstart,
   output logic [SLOT_W-1:0]  p0,
   output logic [SLOT_W-1:0]  pend,
   output logic [LANE_SH-1:0] lead,
   output logic               first,
   output logic               last,
   output logic               zlen,
   output logic [POP_W-1:0]   pop_cnt
);

   typedef enum logic {S_IDLE, S_SEND} st_t;

   localparam int DESC_BEATS = (DESC_WORDS + LANES - 1) / LANES;
   localparam int ALN_BASE   = DESC_BEATS * LANES;

   st_t               st;
   logic [SLOT_W-1:0] beat;
   logic [SLOT_W-1:0] p0_in, npl_in, bnext, lo, hi, npay;
   logic [LANE_SH-1:0] off_in;
   logic              cmd_fire;

   assign off_in    = cmd_in.addr[2 +: LANE_SH];
   assign cmd_ready = (st == S_IDLE) && (SLOT_W'(level) >= SLOT_W'(cmd_in.len));
   assign cmd_fire  = cmd_valid && cmd_ready;
   assign p0_in     = cmd_in.aligned ? SLOT_W'(ALN_BASE) + SLOT_W'(off_in)
                                     : SLOT_W'(DESC_WORDS);
   assign npl_in    = (cmd_in.len == '0) ? SLOT_W'(1) : SLOT_W'(cmd_in.len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         beat  <= '0;
         cmd_q <= '0;
         p0    <= '0;
         pend  <= '0;
      end else if (cmd_fire) begin
         st    <= S_SEND;
         beat  <= '0;
         cmd_q <= cmd_in;
         p0    <= p0_in;
         pend  <= p0_in + npl_in;
      end else if (beat_fire) begin
         if (last) st <= S_IDLE;
         else      beat <= beat + SLOT_W'(1);
      end
   end

   always_comb begin
      bstart  = beat << LANE_SH;
      bnext   = bstart + SLOT_W'(LANES);
      lo      = (p0 > bstart) ? p0 : bstart;
      hi      = (pend < bnext) ? pend : bnext;
      npay    = (hi > lo) ? hi - lo : '0;
      lead    = LANE_SH'(lo - bstart);
      last    = (pend <= bnext);
      first   = (beat == '0);
      zlen    = (cmd_q.len == '0);
      busy    = (st == S_SEND);
      pop_cnt = (beat_fire && !zlen) ? POP_W'(npay) : '0;
   end

endmodule

// File: rtl/mwp_packetizer.sv
module mwp_packetizer
   import mwp_pkg::*;
#(
   parameter int         LANES      = 4,
   parameter int         FIFO_DEPTH = 16,
   parameter logic [3:0] WR_TYPE    = 4'b0001,
   localparam int LANE_SH = $clog2(LANES),
   localparam int CNT_W   = $clog2(FIFO_DEPTH) + 1,
   localparam int POP_W   = $clog2(LANES + 1),
   localparam int SLOT_W  = $clog2(DESC_WORDS + 2 * LANES + (1 << CNT_BITS)) + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   output logic                   cmd_ready,
   input  logic [63:0]            cmd_addr,
   input  logic [CNT_BITS-1:0]    cmd_dw_len,
   input  logic [3:0]             cmd_first_be,
   input  logic [3:0]             cmd_last_be,
   input  logic                   cmd_addr_aligned,
   input  logic                   pl_valid,
   input  logic [31:0]            pl_data,
   output logic                   pl_ready,
   output logic                   m_tvalid,
   input  logic                   m_tready,
   output logic [32*LANES-1:0]    m_tdata,
   output logic [LANES-1:0]       m_tkeep,
   output logic                   m_tlast,
   output logic [USER_BITS-1:0]   m_tuser
);

   if (LANES != 4 && LANES != 8) begin : g_bad_lanes
      $error("mwp_packetizer: LANES must be 4 or 8");
   end

   mwp_cmd_t                cmd_in, cmd_q;
   logic                    busy, first, last, zlen, beat_fire;
   logic [SLOT_W-1:0]       bstart, p0, pend;
   logic [LANE_SH-1:0]      lead;
   logic [POP_W-1:0]        pop_cnt;
   logic [CNT_W-1:0]        level;
   logic [LANES-1:0][31:0]  win;
   logic [2:0]              start_lane;

   assign cmd_in = '{addr: cmd_addr, len: cmd_dw_len, first_be: cmd_first_be,
                     last_be: cmd_last_be, aligned: cmd_addr_aligned};
   assign beat_fire = busy && m_tready;

   mwp_dw_fifo #(.DEPTH(FIFO_DEPTH), .LANES(LANES)) fifo_i (
      .clk(clk), .rst_n(rst_n),
      .push_valid(pl_valid), .push_data(pl_data), .push_ready(pl_ready),
      .pop_cnt(pop_cnt), .win(win), .level(level));

   mwp_seq #(.LANES(LANES), .DEPTH(FIFO_DEPTH), .SLOT_W(SLOT_W)) seq_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_in(cmd_in), .cmd_ready(cmd_ready),
      .level(level), .beat_fire(beat_fire), .busy(busy), .cmd_q(cmd_q),
      .bstart(bstart), .p0(p0), .pend(pend), .lead(lead),
      .first(first), .last(last), .zlen(zlen), .pop_cnt(pop_cnt));

   // Lane builder: each lane decodes its global word slot.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [SLOT_W-1:0]  slot;
      logic [LANE_SH-1:0] widx;
      logic [31:0]        word;
      assign slot = bstart + SLOT_W'(l);
      assign widx = LANE_SH'(l) - lead;
      always_comb begin
         if (slot < SLOT_W'(DESC_WORDS))
            word = desc_word(cmd_q, int'(slot), WR_TYPE);
         else if (slot < p0 || slot >= pend || zlen)
            word = '0;
         else
            word = win[widx];
      end
      assign m_tdata[32*l +: 32] = word;
      assign m_tkeep[l]          = busy && (slot < pend);
   end

   assign start_lane = cmd_q.aligned ? 3'(cmd_q.addr[2 +: LANE_SH]) : 3'd0;
   assign m_tvalid   = busy;
   assign m_tlast    = busy && last;

   always_comb begin
      if (!busy || !first)
         m_tuser = '0;
      else if (zlen)
         m_tuser = {start_lane, 8'h00};
      else
         m_tuser = {start_lane, cmd_q.last_be, cmd_q.first_be};
   end

endmodule

// File: rtl/mwp_chk.sv
module mwp_chk #(
   parameter int         LANES   = 4,
   parameter logic [3:0] WR_TYPE = 4'b0001
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m_tvalid,
   input logic              m_tready,
   input logic [LANES-1:0]  m_tkeep,
   input logic              m_tlast,
   input logic [10:0]       m_tuser,
   input logic [3:0]        d_type,
   input logic [1:0]        d_alo,
   input logic [31:0]       d_lane0,
   input logic              cmd_ready
);

   logic sop;
   always_ff @(posedge clk) begin
      if (!rst_n) sop <= 1'b1;
      else if (m_tvalid && m_tready) sop <= m_tlast;
   end

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && !m_tready |=> m_tvalid && $stable(m_tkeep) && $stable(m_tlast)
                               && $stable(m_tuser) && $stable(d_lane0));
   // R6
   no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && m_tready && !m_tlast |=> m_tvalid);
   // R5
   keep_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> (m_tkeep != '0) && ((m_tkeep & LANES'(m_tkeep + 1'b1)) == '0));
   // R5
   keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && !m_tlast |-> (&m_tkeep));
   // R4
   user_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && !sop |-> m_tuser == '0);
   // R1
   desc_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && sop |-> d_type == WR_TYPE && d_alo == 2'b00);
   // R10
   busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> !cmd_ready);

endmodule

bind mwp_packetizer mwp_chk #(.LANES(LANES), .WR_TYPE(WR_TYPE)) chk_i (
   .clk(clk), .rst_n(rst_n), .m_tvalid(m_tvalid), .m_tready(m_tready),
   .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tuser(m_tuser),
   .d_type(m_tdata[78:75]), .d_alo(m_tdata[1:0]), .d_lane0(m_tdata[31:0]),
   .cmd_ready(cmd_ready));

// File: tb/mwp_packetizer_tb_top.sv
module mwp_packetizer_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic         cmd_ready;
   logic [63:0]  cmd_addr = '0;
   logic [10:0]  cmd_dw_len = '0;
   logic [3:0]   cmd_first_be = '0;
   logic [3:0]   cmd_last_be = '0;
   logic         cmd_addr_aligned = 1'b0;
   logic         pl_valid = 1'b0;
   logic [31:0]  pl_data = '0;
   logic         pl_ready;
   logic         m_tvalid;
   logic         m_tready = 1'b0;
   logic [127:0] m_tdata;
   logic [3:0]   m_tkeep;
   logic         m_tlast;
   logic [10:0]  m_tuser;

   int checks = 0;
   int failures = 0;
   bit bp_en = 1'b0;
   bit done = 1'b0;

   logic [127:0] exp_d[$];
   logic [3:0]   exp_k[$];
   logic         exp_l[$];
   logic [10:0]  exp_u[$];
   string        exp_t[$];
   logic [31:0]  pl_model[$];

   always #10 clk = ~clk;

   mwp_packetizer #(.LANES(4), .FIFO_DEPTH(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_dw_len(cmd_dw_len), .cmd_first_be(cmd_first_be),
      .cmd_last_be(cmd_last_be), .cmd_addr_aligned(cmd_addr_aligned),
      .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
      .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
      .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tuser(m_tuser));

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // Monitor: drives tready and compares accepted beats to the scoreboard.
   logic [127:0] h_d;
   logic [3:0]   h_k;
   logic         h_l;
   logic [10:0]  h_u;
   bit           held = 1'b0;
   bit           cont = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         m_tready = 1'b0;
         held = 1'b0;
         cont = 1'b0;
      end else begin
         if (held) begin
            checks++;
            if (m_tdata !== h_d || m_tkeep !== h_k || m_tlast !== h_l || m_tuser !== h_u || !m_tvalid) begin
               failures++;
               $display("FAIL R7 hold: data=%h keep=%b user=%h exp data=%h keep=%b user=%h",
                        m_tdata, m_tkeep, m_tuser, h_d, h_k, h_u);
            end
         end
         if (cont) begin
            checks++;
            if (m_tvalid !== 1'b1) begin
               failures++;
               $display("FAIL R6 gap: tvalid=%b exp=1", m_tvalid);
            end
         end
         if (m_tvalid) begin
            checks++;
            if (cmd_ready !== 1'b0) begin
               failures++;
               $display("FAIL R10 busy: cmd_ready=%b exp=0", cmd_ready);
            end
         end
         m_tready = bp_en ? (($urandom % 3) != 0) : 1'b1;
         held = 1'b0;
         cont = 1'b0;
         if (m_tvalid) begin
            if (m_tready) begin
               checks++;
               if (exp_d.size() == 0) begin
                  failures++;
                  $display("FAIL R6 extra beat: data=%h exp=none", m_tdata);
               end else begin
                  logic [127:0] ed;
                  logic [3:0]   ek;
                  logic         el;
                  logic [10:0]  eu;
                  string        et;
                  ed = exp_d.pop_front(); ek = exp_k.pop_front();
                  el = exp_l.pop_front(); eu = exp_u.pop_front();
                  et = exp_t.pop_front();
                  if (m_tdata !== ed || m_tkeep !== ek || m_tlast !== el || m_tuser !== eu) begin
                     failures++;
                     $display("FAIL %s beat: data=%h keep=%b last=%b user=%h exp data=%h keep=%b last=%b user=%h",
                              et, m_tdata, m_tkeep, m_tlast, m_tuser, ed, ek, el, eu);
                  end
               end
               cont = !m_tlast;
            end else begin
               held = 1'b1;
               h_d = m_tdata; h_k = m_tkeep; h_l = m_tlast; h_u = m_tuser;
            end
         end
      end
   end

   task automatic push_word(input logic [31:0] w);
      @(negedge clk);
      while (!pl_ready) @(negedge clk);
      pl_valid = 1'b1;
      pl_data = w;
      pl_model.push_back(w);
      @(negedge clk);
      pl_valid = 1'b0;
   endtask

   // Driver: queue payload, build expected beats, then offer the command.
   task automatic send(input logic [63:0] a, input int len, input logic [3:0] fb,
                       input logic [3:0] lb, input logic al, input string tag);
      logic [31:0] w[$];
      int p0, npl, endp, nb;
      for (int i = 0; i < len; i++) push_word($urandom);
      for (int i = 0; i < len; i++) w.push_back(pl_model.pop_front());
      p0 = al ? 4 + int'(a[3:2]) : 4;
      npl = (len == 0) ? 1 : len;
      endp = p0 + npl;
      nb = (endp + 3) / 4;
      for (int b = 0; b < nb; b++) begin
         logic [127:0] d;
         logic [3:0]   k;
         logic [10:0]  u;
         for (int l = 0; l < 4; l++) begin
            int s;
            logic [31:0] v;
            s = b * 4 + l;
            if (s == 0)        v = {a[31:2], 2'b00};
            else if (s == 1)   v = a[63:32];
            else if (s == 2)   v = {17'd0, 4'b0001, 11'(npl)};
            else if (s < p0)   v = '0;
            else if (s < endp) v = (len == 0) ? 32'd0 : w[s - p0];
            else               v = '0;
            d[32*l +: 32] = v;
            k[l] = (s < endp);
         end
         if (b != 0)        u = '0;
         else if (len == 0) u = {(al ? {1'b0, a[3:2]} : 3'd0), 8'h00};
         else               u = {(al ? {1'b0, a[3:2]} : 3'd0), lb, fb};
         exp_d.push_back(d); exp_k.push_back(k); exp_l.push_back(b == nb - 1);
         exp_u.push_back(u); exp_t.push_back(tag);
      end
      @(negedge clk);
      cmd_valid = 1'b1; cmd_addr = a; cmd_dw_len = 11'(len);
      cmd_first_be = fb; cmd_last_be = lb; cmd_addr_aligned = al;
      #1;
      while (!cmd_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_d.size() != 0 || m_tvalid) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R6 watchdog: state=hung exp=finished");
         summary();
      end
   end

   initial begin
      repeat (4) begin
         @(negedge clk);
         checks++;
         if (m_tvalid !== 1'b0) begin
            failures++;
            $display("FAIL R11 reset: tvalid=%b exp=0", m_tvalid);
         end
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (m_tvalid !== 1'b0) begin
         failures++;
         $display("FAIL R11 after reset: tvalid=%b exp=0", m_tvalid);
      end

      // R10: one word queued, three requested -> no acceptance, no beat
      push_word(32'hA5A5_0001);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_dw_len = 11'd3; cmd_addr = 64'h100;
      repeat (3) begin
         #1;
         checks++;
         if (cmd_ready !== 1'b0 || m_tvalid !== 1'b0) begin
            failures++;
            $display("FAIL R10 short fifo: cmd_ready=%b tvalid=%b exp 0 0", cmd_ready, m_tvalid);
         end
         @(negedge clk);
      end
      cmd_valid = 1'b0;

      send(64'h0000_0012_3456_7800, 5, 4'hF, 4'h3, 1'b0, "R2");
      drain();
      send(64'h0000_0000_0000_1008, 3, 4'hC, 4'h1, 1'b1, "R3");
      drain();
      send(64'h0000_0000_0000_2000, 0, 4'hF, 4'hF, 1'b0, "R8");
      drain();
      send(64'h0000_0000_0000_3000, 2, 4'h6, 4'hE, 1'b1, "R5");
      drain();
      send(64'hFFFF_0000_0000_4010, 4, 4'hF, 4'hF, 1'b0, "R1");
      drain();
      send(64'h0000_0000_0000_500C, 1, 4'h9, 4'h0, 1'b1, "R4");
      drain();
      // R9: queued words survive a zero-length write
      push_word(32'hDEAD_0001);
      push_word(32'hDEAD_0002);
      send(64'h0000_0000_0000_6004, 0, 4'h0, 4'h0, 1'b1, "R9");
      send(64'h0000_0000_0000_7000, 2, 4'hF, 4'h7, 1'b0, "R9");
      drain();

      bp_en = 1'b1;
      for (int i = 0; i < 30; i++) begin
         int len;
         logic al;
         len = $urandom % 12;
         al = 1'($urandom % 2);
         send({$urandom, $urandom}, len, 4'($urandom), 4'($urandom), al,
              len == 0 ? "R8" : (al ? "R3" : "R2"));
      end
      drain();
      bp_en = 1'b0;

      checks++;
      if (exp_d.size() != 0) begin
         failures++;
         $display("FAIL R6 missing beats: left=%0d exp=0", exp_d.size());
      end
      done = 1'b1;
      summary();
   end

endmodule